// File: doc/BRIEF.md
# Interrupt Stacking and Return Sequencer

This block runs the interrupt entry and exit steps for a small CPU with 8-bit and 16-bit registers. The core raises `boundary` when an instruction has completed. If a request can be taken at that point, the sequencer snapshots the register file and the return address and signals a flush of the instruction queue. It then writes a nine-byte frame below the stack pointer, one byte per memory handshake. After the frame it reads the vector of the request that won at acceptance and presents a complete register load (new program counter, masked condition codes, lowered stack pointer) in a single `loadValid` cycle.

When the core decodes a return-from-interrupt, it raises `rtiReq` together with `boundary`. The sequencer first reads the stacked condition-code byte. If a request can be taken under that byte's mask bits, the sequencer does not unstack the frame. It leaves the stack pointer on the stacked condition-code byte, fetches the new vector and starts the next handler at once. If no request qualifies, it reads the other eight bytes and restores every register.

The core must not fetch while `busy` is high. Condition-code bit 4 is the maskable interrupt mask (I) and bit 6 is the non-maskable mask (X).

Top module: `irq_stack_seq`

## Requirements
- R1: When the sequencer is idle, a `boundary` cycle without `rtiReq` starts entry in two cases: some `irqReq` line is high while `ccrIn` bit 4 is clear, or `xirqReq` is high while `ccrIn` bit 6 is clear (whatever the value of bit 4). In every other case nothing starts: `busy` and `memReq` stay low.
- R2: Entry performs nine writes, to addresses E-1 down to E-9 (E is `spIn` at acceptance). The bytes written are, in that order: return address low, return address high, Y low, Y high, X low, X high, accumulator low, accumulator high, and the unmodified `ccrIn`. A return never writes.
- R3: After entry, `spOut` is E-9. `yOut`, `xOut` and `accOut` equal the values captured at acceptance.
- R4: After entry, `ccrOut` is the captured condition-code byte with bit 4 set. Bit 6 is also set if `xirqReq` was high at acceptance.
- R5: The winner gets a priority index: `xirqReq` is index 0 and `irqReq[i]` is index i+1, and the lowest qualifying index wins. The vector read address is 0xFFF4 minus twice the index. `pcOut` takes the 16-bit word returned. The winner is fixed at acceptance, so later changes to the requests do not alter it.
- R6: A return that has nothing pending reads the nine bytes at S..S+8 (S is `spIn` at the return). It restores Y, X, the accumulator, the condition codes and the return address from those bytes, and `spOut` becomes S+9.
- R7: A return whose stacked condition-code byte admits a pending request (R1 rules applied to that byte) reads only that one byte. `spOut` stays S. `ccrOut` is the stacked byte with bit 4 set, and bit 6 set as well if `xirqReq` is high. `pcOut` is the new vector, and Y, X and the accumulator pass through from the inputs.
- R8: Once `memReq` or `vecReq` is raised, it stays high with a stable address, direction and write data until its ready input is sampled high.
- R9: `busy` is high from the cycle after acceptance through the single `loadValid` cycle, and it falls right after that cycle.
- R10: `boundary` is ignored while `busy` is high. At a boundary where `rtiReq` is high, the return is started even if a request is pending.
- R11: `flushQ` pulses for exactly one cycle, in the cycle after an entry is accepted. It never pulses for a return.
- R12: After reset, `busy`, `flushQ`, `loadValid`, `memReq` and `vecReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | An instruction has just completed |
| rtiReq | input | 1 | The instruction at this boundary is a return-from-interrupt |
| irqReq | input | NUM_IRQ | Maskable request lines; a lower index has higher priority |
| xirqReq | input | 1 | Non-maskable request |
| pcIn | input | 16 | Return address computed by the core |
| yIn | input | 16 | Y index register |
| xIn | input | 16 | X index register |
| accIn | input | 16 | Accumulator pair; the high byte goes to the lower address |
| ccrIn | input | 8 | Condition-code register |
| spIn | input | 16 | Stack pointer |
| busy | output | 1 | A sequence is in progress; the core must not fetch |
| flushQ | output | 1 | Flush the instruction queue |
| loadValid | output | 1 | One-cycle strobe: load the register outputs into the core |
| pcOut | output | 16 | New program counter |
| yOut | output | 16 | New Y |
| xOut | output | 16 | New X |
| accOut | output | 16 | New accumulator pair |
| ccrOut | output | 8 | New condition-code register |
| spOut | output | 16 | New stack pointer |
| memReq | output | 1 | Stack memory request |
| memWe | output | 1 | Stack memory write (1) or read (0) |
| memAddr | output | 16 | Stack memory byte address |
| memWdata | output | 8 | Stack write byte |
| memRdata | input | 8 | Stack read byte |
| memReady | input | 1 | Stack memory completes this byte |
| vecReq | output | 1 | Vector table read request |
| vecAddr | output | 16 | Vector table address |
| vecData | input | 16 | Vector word |
| vecReady | input | 1 | Vector word valid |

## Verification
Several rules are checked on every cycle:
- the handshake holds its address, direction and data until ready (R8);
- entry only writes and a return only reads (R2, R7);
- acceptance happens only at an idle boundary under the mask rules (R1, R10);
- the flush and load strobes have the right width and position (R9, R11);
- an entry always ends with the stack pointer lowered by nine and the I bit set (R3, R4).

Other properties can only be shown by the bench's scenarios, where the expected values are worked out independently. These include the exact byte order of the frame, the choice of vector under priority and late arrivals, and the decision between a full restore and a chained handler, which depends on the stacked mask bits.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  localparam int ADDR_W      = 16;
  localparam int FRAME_BYTES = 9;
  localparam int CNT_W       = $clog2(FRAME_BYTES);

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH,
    S_POP,
    S_VEC,
    S_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // snapshot inputs at acceptance
    logic capRti;    // acceptance is a return
    logic cntClr;    // clear byte counter
    logic cntInc;    // advance byte counter
    logic popStore;  // store memRdata into frame register
    logic vecStore;  // store vector word
    logic setChain;  // return chains into a new handler
  } dpCtl_t;

endpackage

// File: rtl/irqs_ctrl.sv
module irqs_ctrl
  import irqs_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   boundary,
  input  logic   rtiReq,
  input  logic   acceptOk,
  input  logic   chainOk,
  input  logic   firstByte,
  input  logic   lastByte,
  input  logic   memReady,
  input  logic   vecReady,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   flushQ,
  output logic   loadValid,
  output logic   memReq,
  output logic   memWe,
  output logic   vecReq,
  output logic   entryGo,
  output logic   rtiGo
);

  seqState_t state, nxt;

  always_comb begin
    nxt       = state;
    ctl       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    vecReq    = 1'b0;
    loadValid = 1'b0;
    entryGo   = 1'b0;
    rtiGo     = 1'b0;
    case (state)
      S_IDLE: begin
        if (boundary) begin
          if (rtiReq) begin
            rtiGo       = 1'b1;
            ctl.capture = 1'b1;
            ctl.capRti  = 1'b1;
            ctl.cntClr  = 1'b1;
            nxt         = S_POP;
          end else if (acceptOk) begin
            entryGo     = 1'b1;
            ctl.capture = 1'b1;
            ctl.cntClr  = 1'b1;
            nxt         = S_PUSH;
          end
        end
      end
      S_PUSH: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) begin
          if (lastByte) nxt = S_VEC;
          else          ctl.cntInc = 1'b1;
        end
      end
      S_POP: begin
        memReq = 1'b1;
        if (memReady) begin
          ctl.popStore = 1'b1;
          if (firstByte && chainOk) begin
            ctl.setChain = 1'b1;
            nxt          = S_VEC;
          end else if (lastByte) begin
            nxt = S_DONE;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
      end
      S_VEC: begin
        vecReq = 1'b1;
        if (vecReady) begin
          ctl.vecStore = 1'b1;
          nxt          = S_DONE;
        end
      end
      S_DONE: begin
        loadValid = 1'b1;
        nxt       = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      flushQ <= 1'b0;
    end else begin
      state  <= nxt;
      flushQ <= entryGo;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/irqs_dpath.sv
module irqs_dpath
  import irqs_pkg::*;
#(
  parameter int          NUM_IRQ  = 8,
  parameter logic [15:0] VEC_BASE = 16'hFFF4,
  parameter int          I_BIT    = 4,
  parameter int          X_BIT    = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic               memWe,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               xirqReq,
  input  logic [15:0]        pcIn,
  input  logic [15:0]        yIn,
  input  logic [15:0]        xIn,
  input  logic [15:0]        accIn,
  input  logic [7:0]         ccrIn,
  input  logic [ADDR_W-1:0]  spIn,
  input  logic [7:0]         memRdata,
  input  logic [15:0]        vecData,
  output logic               acceptOk,
  output logic               chainOk,
  output logic               firstByte,
  output logic               lastByte,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [7:0]         memWdata,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [15:0]        pcOut,
  output logic [15:0]        yOut,
  output logic [15:0]        xOut,
  output logic [15:0]        accOut,
  output logic [7:0]         ccrOut,
  output logic [ADDR_W-1:0]  spOut
);

  localparam int IDX_W = $clog2(NUM_IRQ + 1);
  localparam logic [7:0] I_MASK = 8'(1 << I_BIT);
  localparam logic [7:0] X_MASK = 8'(1 << X_BIT);
  localparam logic [ADDR_W-1:0] FRAME_SZ = ADDR_W'(FRAME_BYTES);

  // {valid, index}: xirq is index 0, line i is index i+1, lowest wins
  function automatic logic [IDX_W:0] pickWinner(
    input logic               xr,
    input logic [NUM_IRQ-1:0] rq,
    input logic [7:0]         cc
  );
    logic             v;
    logic [IDX_W-1:0] ix;
    v  = 1'b0;
    ix = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (rq[i] && !cc[I_BIT]) begin
        v  = 1'b1;
        ix = IDX_W'(i + 1);
      end
    end
    if (xr && !cc[X_BIT]) begin
      v  = 1'b1;
      ix = '0;
    end
    return {v, ix};
  endfunction

  logic [IDX_W:0] entryPick, chainPick;
  assign entryPick = pickWinner(xirqReq, irqReq, ccrIn);
  assign chainPick = pickWinner(xirqReq, irqReq, memRdata);
  assign acceptOk  = entryPick[IDX_W];
  assign chainOk   = chainPick[IDX_W];

  // snapshot and sequence state
  logic [15:0]       pcS, yS, xS, accS;
  logic [7:0]        ccrS;
  logic [ADDR_W-1:0] spS;
  logic              rtiMode, chainQ, xLatch;
  logic [IDX_W-1:0]  winIdx;
  logic [CNT_W-1:0]  cnt;
  // frame read back
  logic [15:0]       pcP, yP, xP, accP, vecQ;
  logic [7:0]        ccrP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcS <= '0; yS <= '0; xS <= '0; accS <= '0; ccrS <= '0; spS <= '0;
      rtiMode <= 1'b0; chainQ <= 1'b0; xLatch <= 1'b0; winIdx <= '0;
      cnt <= '0;
    end else begin
      if (ctl.capture) begin
        pcS     <= pcIn;
        yS      <= yIn;
        xS      <= xIn;
        accS    <= accIn;
        ccrS    <= ccrIn;
        spS     <= spIn;
        rtiMode <= ctl.capRti;
        chainQ  <= 1'b0;
        if (!ctl.capRti) begin
          winIdx <= entryPick[IDX_W-1:0];
          xLatch <= xirqReq;
        end
      end
      if (ctl.setChain) begin
        chainQ <= 1'b1;
        winIdx <= chainPick[IDX_W-1:0];
        xLatch <= xirqReq;
      end
      if (ctl.cntClr)      cnt <= '0;
      else if (ctl.cntInc) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcP <= '0; yP <= '0; xP <= '0; accP <= '0; ccrP <= '0; vecQ <= '0;
    end else begin
      if (ctl.popStore) begin
        case (cnt)
          4'd0:    ccrP        <= memRdata;
          4'd1:    accP[15:8]  <= memRdata;
          4'd2:    accP[7:0]   <= memRdata;
          4'd3:    xP[15:8]    <= memRdata;
          4'd4:    xP[7:0]     <= memRdata;
          4'd5:    yP[15:8]    <= memRdata;
          4'd6:    yP[7:0]     <= memRdata;
          4'd7:    pcP[15:8]   <= memRdata;
          default: pcP[7:0]    <= memRdata;
        endcase
      end
      if (ctl.vecStore) vecQ <= vecData;
    end
  end

  assign firstByte = (cnt == '0);
  assign lastByte  = (cnt == CNT_W'(FRAME_BYTES - 1));

  // writes descend from E-1, reads ascend from S
  assign memAddr = memWe ? (spS - ADDR_W'(cnt) - 1'b1) : (spS + ADDR_W'(cnt));

  always_comb begin
    case (cnt)
      4'd0:    memWdata = pcS[7:0];
      4'd1:    memWdata = pcS[15:8];
      4'd2:    memWdata = yS[7:0];
      4'd3:    memWdata = yS[15:8];
      4'd4:    memWdata = xS[7:0];
      4'd5:    memWdata = xS[15:8];
      4'd6:    memWdata = accS[7:0];
      4'd7:    memWdata = accS[15:8];
      default: memWdata = ccrS;
    endcase
  end

  assign vecAddr = VEC_BASE - (ADDR_W'(winIdx) << 1);

  logic       normalRet;
  logic [7:0] maskBase;
  assign normalRet = rtiMode && !chainQ;
  assign maskBase  = rtiMode ? ccrP : ccrS;

  assign pcOut  = normalRet ? pcP  : vecQ;
  assign yOut   = normalRet ? yP   : yS;
  assign xOut   = normalRet ? xP   : xS;
  assign accOut = normalRet ? accP : accS;
  assign ccrOut = normalRet ? ccrP : (maskBase | I_MASK | (xLatch ? X_MASK : 8'h00));
  assign spOut  = normalRet ? (spS + FRAME_SZ) : (rtiMode ? spS : (spS - FRAME_SZ));

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irqs_pkg::*;
#(
  parameter int          NUM_IRQ  = 8,
  parameter logic [15:0] VEC_BASE = 16'hFFF4,
  parameter int          I_BIT    = 4,
  parameter int          X_BIT    = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               boundary,
  input  logic               rtiReq,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               xirqReq,
  input  logic [15:0]        pcIn,
  input  logic [15:0]        yIn,
  input  logic [15:0]        xIn,
  input  logic [15:0]        accIn,
  input  logic [7:0]         ccrIn,
  input  logic [15:0]        spIn,
  output logic               busy,
  output logic               flushQ,
  output logic               loadValid,
  output logic [15:0]        pcOut,
  output logic [15:0]        yOut,
  output logic [15:0]        xOut,
  output logic [15:0]        accOut,
  output logic [7:0]         ccrOut,
  output logic [15:0]        spOut,
  output logic               memReq,
  output logic               memWe,
  output logic [15:0]        memAddr,
  output logic [7:0]         memWdata,
  input  logic [7:0]         memRdata,
  input  logic               memReady,
  output logic               vecReq,
  output logic [15:0]        vecAddr,
  input  logic [15:0]        vecData,
  input  logic               vecReady
);

  dpCtl_t ctl;
  logic   acceptOk, chainOk, firstByte, lastByte;
  logic   entryGo, rtiGo;

  irqs_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .boundary  (boundary),
    .rtiReq    (rtiReq),
    .acceptOk  (acceptOk),
    .chainOk   (chainOk),
    .firstByte (firstByte),
    .lastByte  (lastByte),
    .memReady  (memReady),
    .vecReady  (vecReady),
    .ctl       (ctl),
    .busy      (busy),
    .flushQ    (flushQ),
    .loadValid (loadValid),
    .memReq    (memReq),
    .memWe     (memWe),
    .vecReq    (vecReq),
    .entryGo   (entryGo),
    .rtiGo     (rtiGo)
  );

  irqs_dpath #(
    .NUM_IRQ  (NUM_IRQ),
    .VEC_BASE (VEC_BASE),
    .I_BIT    (I_BIT),
    .X_BIT    (X_BIT)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .memWe     (memWe),
    .irqReq    (irqReq),
    .xirqReq   (xirqReq),
    .pcIn      (pcIn),
    .yIn       (yIn),
    .xIn       (xIn),
    .accIn     (accIn),
    .ccrIn     (ccrIn),
    .spIn      (spIn),
    .memRdata  (memRdata),
    .vecData   (vecData),
    .acceptOk  (acceptOk),
    .chainOk   (chainOk),
    .firstByte (firstByte),
    .lastByte  (lastByte),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .vecAddr   (vecAddr),
    .pcOut     (pcOut),
    .yOut      (yOut),
    .xOut      (xOut),
    .accOut    (accOut),
    .ccrOut    (ccrOut),
    .spOut     (spOut)
  );

endmodule

// File: rtl/irqs_check.sv
module irqs_check #(
  parameter int NUM_IRQ = 8,
  parameter int I_BIT   = 4,
  parameter int X_BIT   = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               boundary,
  input logic [NUM_IRQ-1:0] irqReq,
  input logic               xirqReq,
  input logic [7:0]         ccrIn,
  input logic [15:0]        spIn,
  input logic               busy,
  input logic               flushQ,
  input logic               loadValid,
  input logic [7:0]         ccrOut,
  input logic [15:0]        spOut,
  input logic               memReq,
  input logic               memWe,
  input logic [15:0]        memAddr,
  input logic [7:0]         memWdata,
  input logic               memReady,
  input logic               vecReq,
  input logic [15:0]        vecAddr,
  input logic               vecReady,
  input logic               entryGo,
  input logic               rtiGo
);

  logic        modeEntry, modeRti;
  logic [15:0] savedSp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeEntry <= 1'b0;
      modeRti   <= 1'b0;
      savedSp   <= '0;
    end else if (entryGo) begin
      modeEntry <= 1'b1;
      modeRti   <= 1'b0;
      savedSp   <= spIn;
    end else if (rtiGo) begin
      modeEntry <= 1'b0;
      modeRti   <= 1'b1;
    end
  end

  p_accept_mask_r1: assert property (@(posedge clk) disable iff (!rstN)
    entryGo |-> ((xirqReq && !ccrIn[X_BIT]) || ((|irqReq) && !ccrIn[I_BIT])));

  p_entry_writes_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && modeEntry) |-> memWe);

  p_sp_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && modeEntry) |-> (spOut == savedSp - 16'd9));

  p_ccr_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && modeEntry) |-> ccrOut[I_BIT]);

  p_vec_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (vecReq && !vecReady) |=> (vecReq && $stable(vecAddr)));

  p_return_reads_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && modeRti) |-> !memWe);

  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=>
      (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  p_load_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> busy);

  p_load_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> !busy);

  p_req_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq || vecReq) |-> busy);

  p_idle_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (entryGo || rtiGo) |-> (boundary && !busy));

  p_flush_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    flushQ |=> !flushQ);

  p_flush_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    flushQ |-> (busy && modeEntry));

endmodule

bind irq_stack_seq irqs_check #(
  .NUM_IRQ (NUM_IRQ),
  .I_BIT   (I_BIT),
  .X_BIT   (X_BIT)
) u_check (
  .clk       (clk),
  .rstN      (rstN),
  .boundary  (boundary),
  .irqReq    (irqReq),
  .xirqReq   (xirqReq),
  .ccrIn     (ccrIn),
  .spIn      (spIn),
  .busy      (busy),
  .flushQ    (flushQ),
  .loadValid (loadValid),
  .ccrOut    (ccrOut),
  .spOut     (spOut),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .memWdata  (memWdata),
  .memReady  (memReady),
  .vecReq    (vecReq),
  .vecAddr   (vecAddr),
  .vecReady  (vecReady),
  .entryGo   (entryGo),
  .rtiGo     (rtiGo)
);

// File: tb/irq_stack_seq_test.sv
`timescale 1ns/1ps
module irq_stack_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        boundary = 1'b0, rtiReq = 1'b0, xirqReq = 1'b0;
  logic [7:0]  irqReq = '0;
  logic [15:0] pcIn = '0, yIn = '0, xIn = '0, accIn = '0, spIn = '0;
  logic [7:0]  ccrIn = '0;
  logic        busy, flushQ, loadValid, memReq, memWe, vecReq;
  logic [15:0] pcOut, yOut, xOut, accOut, spOut, memAddr, vecAddr;
  logic [7:0]  ccrOut, memWdata;
  logic [7:0]  memRdata = '0;
  logic        memReady = 1'b0, vecReady = 1'b0;
  logic [15:0] vecData = '0;

  always #2.5 clk = ~clk;

  irq_stack_seq uut (
    .clk(clk), .rstN(rstN), .boundary(boundary), .rtiReq(rtiReq),
    .irqReq(irqReq), .xirqReq(xirqReq), .pcIn(pcIn), .yIn(yIn), .xIn(xIn),
    .accIn(accIn), .ccrIn(ccrIn), .spIn(spIn), .busy(busy), .flushQ(flushQ),
    .loadValid(loadValid), .pcOut(pcOut), .yOut(yOut), .xOut(xOut),
    .accOut(accOut), .ccrOut(ccrOut), .spOut(spOut), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady), .vecReq(vecReq),
    .vecAddr(vecAddr), .vecData(vecData), .vecReady(vecReady)
  );

  int checks = 0;
  int failures = 0;

  // stack memory and vector table responders
  logic [7:0]  mem [0:255];
  logic [15:0] logAddr [0:15];
  logic [7:0]  logData [0:15];
  int wrN = 0, rdN = 0;
  int memWait = 0, vecWait = 0;

  function automatic logic [15:0] vtab(input logic [15:0] a);
    return a ^ 16'h5AC3;
  endfunction

  always @(negedge clk) begin
    if (memReady) begin
      memReady = 1'b0;
      memWait  = $urandom % 3;
    end else if (memReq) begin
      if (memWait == 0) begin
        memReady = 1'b1;
        if (memWe) begin
          mem[memAddr[7:0]] = memWdata;
          if (wrN < 16) begin
            logAddr[wrN] = memAddr;
            logData[wrN] = memWdata;
          end
          wrN++;
        end else begin
          memRdata = mem[memAddr[7:0]];
          rdN++;
        end
      end else memWait--;
    end
  end

  always @(negedge clk) begin
    if (vecReady) begin
      vecReady = 1'b0;
      vecWait  = $urandom % 3;
    end else if (vecReq) begin
      if (vecWait == 0) begin
        vecReady = 1'b1;
        vecData  = vtab(vecAddr);
      end else vecWait--;
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  function automatic int expIdx(input bit x, input logic [7:0] r, input logic [7:0] c);
    if (x && !c[6]) return 0;
    for (int i = 0; i < 8; i++) if (r[i] && !c[4]) return i + 1;
    return -1;
  endfunction

  task automatic waitLoad(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (loadValid) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  // recorded frame of the last entry
  logic [15:0] frPc, frY, frX, frAcc, frSp;
  logic [7:0]  frCcr;

  task automatic doEntry(input logic [15:0] pc, input logic [15:0] y,
                         input logic [15:0] x, input logic [15:0] acc,
                         input logic [7:0] ccr, input logic [15:0] sp,
                         input logic [7:0] irq, input bit xr, input bit disturb,
                         output bit accepted);
    int          idx;
    bit          ok;
    logic [15:0] va;
    logic [7:0]  expB [0:8];
    idx = expIdx(xr, irq, ccr);
    accepted = (idx >= 0);
    @(negedge clk);
    wrN = 0; rdN = 0;
    pcIn = pc; yIn = y; xIn = x; accIn = acc; ccrIn = ccr; spIn = sp;
    irqReq = irq; xirqReq = xr; rtiReq = 1'b0; boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    chkEq("R1 busy after boundary", busy, accepted);
    chkEq("R11 flush after entry accept", flushQ, accepted);
    if (!accepted) begin
      repeat (3) @(negedge clk);
      chkEq("R1 no sequence when masked", {busy, memReq}, 2'b00);
      irqReq = '0; xirqReq = 1'b0;
      return;
    end
    if (disturb) begin
      irqReq = 8'hFF; boundary = 1'b1; rtiReq = 1'b1;
      @(negedge clk);
      chkEq("R11 flush one cycle", flushQ, 1'b0);
      boundary = 1'b0; rtiReq = 1'b0;
    end
    waitLoad(ok);
    chkEq("R9 load strobe seen", ok, 1'b1);
    va = 16'hFFF4 - 16'(2 * idx);
    chkEq("R5 vector pc", pcOut, vtab(va));
    chkEq("R3 sp after entry", spOut, sp - 16'd9);
    chkEq("R4 ccr after entry", ccrOut, ccr | 8'h10 | (xr ? 8'h40 : 8'h00));
    chkEq("R3 y passthrough", yOut, y);
    chkEq("R3 x passthrough", xOut, x);
    chkEq("R3 acc passthrough", accOut, acc);
    chkEq("R2 write count", wrN, 9);
    chkEq("R2 no reads in entry", rdN, 0);
    expB[0] = pc[7:0];  expB[1] = pc[15:8];
    expB[2] = y[7:0];   expB[3] = y[15:8];
    expB[4] = x[7:0];   expB[5] = x[15:8];
    expB[6] = acc[7:0]; expB[7] = acc[15:8];
    expB[8] = ccr;
    for (int k = 0; k < 9; k++) begin
      chkEq("R2 frame address", logAddr[k], sp - 16'(k + 1));
      chkEq("R2 frame byte", logData[k], expB[k]);
    end
    @(negedge clk);
    chkEq("R9 busy clears after load", busy, 1'b0);
    frPc = pc; frY = y; frX = x; frAcc = acc; frCcr = ccr; frSp = sp - 16'd9;
    irqReq = '0; xirqReq = 1'b0;
  endtask

  task automatic doReturn(input logic [7:0] irq, input bit xr, input logic [7:0] ccrCore);
    int          idx;
    bit          ok;
    logic [15:0] jy, jx, ja;
    jy = 16'($urandom); jx = 16'($urandom); ja = 16'($urandom);
    idx = expIdx(xr, irq, frCcr);
    @(negedge clk);
    wrN = 0; rdN = 0;
    pcIn = 16'($urandom); yIn = jy; xIn = jx; accIn = ja; ccrIn = ccrCore;
    spIn = frSp; irqReq = irq; xirqReq = xr; rtiReq = 1'b1; boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0; rtiReq = 1'b0;
    chkEq("R10 return started at boundary", busy, 1'b1);
    chkEq("R11 no flush on return", flushQ, 1'b0);
    waitLoad(ok);
    chkEq("R9 return load strobe", ok, 1'b1);
    chkEq("R7 no writes on return", wrN, 0);
    if (idx >= 0) begin
      chkEq("R7 chain read count", rdN, 1);
      chkEq("R7 chain pc", pcOut, vtab(16'hFFF4 - 16'(2 * idx)));
      chkEq("R7 chain sp", spOut, frSp);
      chkEq("R7 chain ccr", ccrOut, frCcr | 8'h10 | (xr ? 8'h40 : 8'h00));
      chkEq("R7 chain y", yOut, jy);
      chkEq("R7 chain x", xOut, jx);
      chkEq("R7 chain acc", accOut, ja);
    end else begin
      chkEq("R6 read count", rdN, 9);
      chkEq("R6 pc", pcOut, frPc);
      chkEq("R6 sp", spOut, frSp + 16'd9);
      chkEq("R6 ccr", ccrOut, frCcr);
      chkEq("R6 y", yOut, frY);
      chkEq("R6 x", xOut, frX);
      chkEq("R6 acc", accOut, frAcc);
    end
    @(negedge clk);
    chkEq("R9 busy clears after return", busy, 1'b0);
    irqReq = '0; xirqReq = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit acc;
    void'($urandom(32'h00C0FFEE));
    repeat (4) @(negedge clk);
    chkEq("R12 reset outputs", {busy, flushQ, loadValid, memReq, vecReq}, 5'b0);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R12 idle after reset", {busy, flushQ, loadValid, memReq, vecReq}, 5'b0);

    // maskable line 3, then plain return
    doEntry(16'h1234, 16'hA1A2, 16'hB1B2, 16'hC1C2, 8'h00, 16'h0080, 8'h08, 1'b0, 1'b0, acc);
    doReturn(8'h00, 1'b0, 8'h10);

    // masked maskable request is ignored (R1)
    doEntry(16'h2222, 16'h1, 16'h2, 16'h3, 8'h10, 16'h0090, 8'h01, 1'b0, 1'b0, acc);

    // non-maskable wins despite I set; return with I set in frame is not chained
    doEntry(16'h4321, 16'h0101, 16'h0202, 16'h0303, 8'h10, 16'h00A0, 8'h03, 1'b1, 1'b0, acc);
    doReturn(8'h04, 1'b0, 8'h00);

    // non-maskable blocked by X
    doEntry(16'h5555, 16'h1, 16'h2, 16'h3, 8'h40, 16'h00A0, 8'h00, 1'b1, 1'b0, acc);

    // late arrivals and boundary during busy (R5, R10), then chained return
    doEntry(16'h6789, 16'h1111, 16'h2222, 16'h3333, 8'h00, 16'h00C0, 8'h80, 1'b0, 1'b1, acc);
    doReturn(8'h02, 1'b0, 8'h00);

    // random mix
    for (int n = 0; n < 30; n++) begin
      logic [7:0] ccr, irq, rirq;
      bit xr, rxr;
      ccr  = 8'($urandom);
      irq  = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
      xr   = ($urandom % 4 == 0);
      rirq = ($urandom % 2 == 0) ? 8'h00 : 8'($urandom);
      rxr  = ($urandom % 5 == 0);
      doEntry(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), ccr,
              16'h0020 + 16'($urandom % 200), irq, xr, ($urandom % 4 == 0), acc);
      if (acc) doReturn(rirq, rxr, 8'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule